// File: doc/BRIEF.md
# Carry/Borrow ALU (16-bit)

This block is the arithmetic and logic stage of a small single-cycle 16-bit processor. Its result is purely combinational from the operands, the immediate and the decoded instruction class, so the surrounding datapath can write it back within the same cycle. Two state bits live inside: a carry bit and a borrow bit. A clock edge updates them only when the clock enable is high. They let software chain 16-bit additions and subtractions into 32-bit ones with add-with-carry and subtract-with-borrow.

The decoder presents one strobe per instruction class: two-operand, one-operand, add-immediate, subtract-immediate and load/store. It also presents a 3-bit function code. Load and store reuse the add-immediate path to form a base-plus-offset address, and they leave the carry alone. Two command inputs force the carry or the borrow to one. The stored carry is exported so a branch unit can test it.

Top module: `alu16`

## Requirements
- R1: A synchronous active-high reset clears both carry and borrow. After reset, carry_out is 0, and a subtract-with-borrow of equal operands yields 0.
- R2: Carry and borrow change only on a clock edge where clk_en is 1. With clk_en at 0 the result is still computed, but both state bits hold.
- R3: With the two-operand strobe, func 0 gives a+b and func 1 gives a+b+carry. With the add-immediate strobe, the result is a plus the 6-bit immediate zero-extended. All three load the carry with the carry-out of bit 15.
- R4: With the two-operand strobe, func 2 gives a-b and func 3 gives a-b-borrow. With the subtract-immediate strobe, the result is a minus the zero-extended immediate. All three set the borrow to 1 when the minuend is below the subtrahend plus any incoming borrow, and clear it otherwise. Only func 3 consumes the stored borrow, and only func 1 consumes the stored carry.
- R5: With the load/store strobe, the result is a plus the zero-extended immediate, and neither carry nor borrow changes.
- R6: set_carry forces carry to 1 and set_borrow forces borrow to 1 at the next enabled edge. Each wins over an arithmetic update of the same bit in that cycle.
- R7: With the two-operand strobe, func 4 gives AND, func 5 OR, func 6 XOR and func 7 XNOR of a and b, and the state bits hold.
- R8: With the one-operand strobe, func 0 gives NOT a and func 1 gives a shifted left by one with bit 0 cleared. Func 2 gives a shifted right by one with bit 15 cleared, and func 3 gives a unchanged. Func 4 to 7 give zero. None of these changes the state bits.
- R9: With no class strobe high, the result is zero and both state bits hold.
- R10: When several class strobes are high, the first one in this order governs: two-operand, one-operand, add-immediate, subtract-immediate, load/store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clk_en | input | 1 | Qualifies every state update |
| rst | input | 1 | Synchronous reset, active high |
| op_two | input | 1 | Two-operand class strobe |
| op_one | input | 1 | One-operand class strobe |
| op_addi | input | 1 | Add-immediate class strobe |
| op_subi | input | 1 | Subtract-immediate class strobe |
| op_mem | input | 1 | Load/store address class strobe |
| func | input | 3 | Function code within the class |
| set_carry | input | 1 | Force carry to 1 |
| set_borrow | input | 1 | Force borrow to 1 |
| opa | input | 16 | First register operand |
| opb | input | 16 | Second register operand |
| imm | input | 6 | Unsigned immediate |
| result | output | 16 | Combinational result |
| carry_out | output | 1 | Stored carry bit |

## Verification
A wrong carry shows on carry_out one cycle after the enabled edge that produced it. It then shows again in the sum of the next add-with-carry. The borrow has no port of its own, so a corrupt borrow stays hidden until a subtract-with-borrow runs. At that point the difference comes out one too low or one too high. The stimulus therefore follows every borrow-setting operation with subtract-with-borrow instructions often enough that a bad borrow surfaces within a few cycles. Edges with the enable low, and load/store cycles that overflow, expose state bits that moved when they should have held.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_TWO,
    CLS_ONE,
    CLS_ADDI,
    CLS_SUBI,
    CLS_MEM
  } op_class_e;

  localparam logic [2:0] FN_ADD  = 3'd0;
  localparam logic [2:0] FN_ADDC = 3'd1;
  localparam logic [2:0] FN_SUB  = 3'd2;
  localparam logic [2:0] FN_SUBB = 3'd3;

  localparam logic [2:0] UN_NOT = 3'd0;
  localparam logic [2:0] UN_SHL = 3'd1;
  localparam logic [2:0] UN_SHR = 3'd2;
  localparam logic [2:0] UN_CP  = 3'd3;

  // Fixed priority among class strobes.
  function automatic op_class_e pick_class(input logic two, input logic one,
                                           input logic addi, input logic subi,
                                           input logic mem);
    if (two)       return CLS_TWO;
    else if (one)  return CLS_ONE;
    else if (addi) return CLS_ADDI;
    else if (subi) return CLS_SUBI;
    else if (mem)  return CLS_MEM;
    else           return CLS_NONE;
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] x,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int XW = W + 1;

  // One extra bit holds the carry-out (add) or the sign of the difference (sub).
  function automatic logic [XW-1:0] add_ext(input logic [W-1:0] p, input logic [W-1:0] q,
                                            input logic c);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [XW-1:0] sub_ext(input logic [W-1:0] p, input logic [W-1:0] q,
                                            input logic bw);
    return {1'b0, p} - {1'b0, q} - {{W{1'b0}}, bw};
  endfunction

  logic [XW-1:0] ext;

  always_comb begin
    if (sub) ext = sub_ext(a, x, cin);
    else     ext = add_ext(a, x, cin);
    res  = ext[W-1:0];
    cout = ext[W];
  end
endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   func,
  output logic [W-1:0] logic_res,
  output logic [W-1:0] unary_res
);
  import alu16_pkg::*;

  always_comb begin
    unique case (func[1:0])
      2'd0:    logic_res = a & b;
      2'd1:    logic_res = a | b;
      2'd2:    logic_res = a ^ b;
      default: logic_res = ~(a ^ b);
    endcase
  end

  always_comb begin
    case (func)
      UN_NOT:  unary_res = ~a;
      UN_SHL:  unary_res = {a[W-2:0], 1'b0};
      UN_SHR:  unary_res = {1'b0, a[W-1:1]};
      UN_CP:   unary_res = a;
      default: unary_res = '0;
    endcase
  end
endmodule

// File: rtl/alu16_state.sv
module alu16_state (
  input  logic clk,
  input  logic clk_en,
  input  logic rst,
  input  logic set_c,
  input  logic set_b,
  input  logic upd_c,
  input  logic upd_b,
  input  logic new_c,
  input  logic new_b,
  output logic carry,
  output logic borrow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      carry  <= 1'b0;
      borrow <= 1'b0;
    end else if (clk_en) begin
      if (set_c)      carry <= 1'b1;
      else if (upd_c) carry <= new_c;
      if (set_b)      borrow <= 1'b1;
      else if (upd_b) borrow <= new_b;
    end
  end
endmodule

// File: rtl/alu16.sv
module alu16 #(
  parameter int W     = 16,
  parameter int IMM_W = 6
) (
  input  logic             clk,
  input  logic             clk_en,
  input  logic             rst,
  input  logic             op_two,
  input  logic             op_one,
  input  logic             op_addi,
  input  logic             op_subi,
  input  logic             op_mem,
  input  logic [2:0]       func,
  input  logic             set_carry,
  input  logic             set_borrow,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     result,
  output logic             carry_out
);
  import alu16_pkg::*;

  localparam int PAD = W - IMM_W;

  op_class_e   cls;
  logic [W-1:0] imm_ext;
  logic [W-1:0] arith_x;
  logic [W-1:0] arith_res;
  logic [W-1:0] logic_res;
  logic [W-1:0] unary_res;
  logic         arith_sub;
  logic         arith_cin;
  logic         arith_cout;
  logic         upd_carry;
  logic         upd_borrow;
  logic         carry_q;
  logic         borrow_q;
  logic         two_arith;

  assign cls       = pick_class(op_two, op_one, op_addi, op_subi, op_mem);
  assign imm_ext   = {{PAD{1'b0}}, imm};
  assign two_arith = (cls == CLS_TWO) && !func[2];

  // Operand and incoming carry/borrow for the shared adder/subtractor.
  always_comb begin
    arith_x   = (cls == CLS_TWO) ? opb : imm_ext;
    arith_sub = (two_arith && func[1]) || (cls == CLS_SUBI);
    arith_cin = 1'b0;
    if (two_arith && func == FN_ADDC) arith_cin = carry_q;
    if (two_arith && func == FN_SUBB) arith_cin = borrow_q;
  end

  assign upd_carry  = (two_arith && !func[1]) || (cls == CLS_ADDI);
  assign upd_borrow = (two_arith &&  func[1]) || (cls == CLS_SUBI);

  alu16_arith #(.W(W)) u_arith (
    .a    (opa),
    .x    (arith_x),
    .sub  (arith_sub),
    .cin  (arith_cin),
    .res  (arith_res),
    .cout (arith_cout)
  );

  alu16_bitops #(.W(W)) u_bits (
    .a         (opa),
    .b         (opb),
    .func      (func),
    .logic_res (logic_res),
    .unary_res (unary_res)
  );

  alu16_state u_state (
    .clk    (clk),
    .clk_en (clk_en),
    .rst    (rst),
    .set_c  (set_carry),
    .set_b  (set_borrow),
    .upd_c  (upd_carry),
    .upd_b  (upd_borrow),
    .new_c  (arith_cout),
    .new_b  (arith_cout),
    .carry  (carry_q),
    .borrow (borrow_q)
  );

  always_comb begin
    case (cls)
      CLS_TWO:                     result = func[2] ? logic_res : arith_res;
      CLS_ONE:                     result = unary_res;
      CLS_ADDI, CLS_SUBI, CLS_MEM: result = arith_res;
      default:                     result = '0;
    endcase
  end

  assign carry_out = carry_q;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         clk_en,
  input logic         rst,
  input logic         op_two,
  input logic         op_one,
  input logic         op_addi,
  input logic         op_subi,
  input logic         op_mem,
  input logic [2:0]   func,
  input logic         set_carry,
  input logic [W-1:0] opa,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         arith_cout,
  input logic         upd_carry
);
  logic any_cls;
  assign any_cls = op_two | op_one | op_addi | op_subi | op_mem;

  // R2: no enable, no state change
  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(carry_out));

  // R3: carry follows the adder carry-out
  a_r3_carry_tracks_adder: assert property (@(posedge clk) disable iff (rst)
    (clk_en && upd_carry && !set_carry) |=> (carry_out == $past(arith_cout)));

  // R5: address generation leaves carry alone
  a_r5_mem_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (clk_en && op_mem && !op_two && !op_one && !op_addi && !op_subi && !set_carry)
      |=> $stable(carry_out));

  // R6: set-carry command
  a_r6_set_carry: assert property (@(posedge clk) disable iff (rst)
    (clk_en && set_carry) |=> carry_out);

  // R8: logical right shift clears the top bit
  a_r8_shr_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (op_one && !op_two && func == 3'd2) |-> (result[W-1] == 1'b0 && result[W-2:0] == opa[W-1:1]));

  // R9: idle result is zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !any_cls |-> (result == '0));
endmodule

bind alu16 alu16_chk #(.W(W)) u_chk (
  .clk        (clk),
  .clk_en     (clk_en),
  .rst        (rst),
  .op_two     (op_two),
  .op_one     (op_one),
  .op_addi    (op_addi),
  .op_subi    (op_subi),
  .op_mem     (op_mem),
  .func       (func),
  .set_carry  (set_carry),
  .opa        (opa),
  .result     (result),
  .carry_out  (carry_out),
  .arith_cout (arith_cout),
  .upd_carry  (upd_carry)
);

// File: tb/sim_alu16.sv
`timescale 1ns/1ps
module sim_alu16;
  logic        clk = 1'b0;
  logic        clk_en, rst;
  logic        op_two, op_one, op_addi, op_subi, op_mem;
  logic [2:0]  func;
  logic        set_carry, set_borrow;
  logic [15:0] opa, opb;
  logic [5:0]  imm;
  logic [15:0] result;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  bit m_c = 1'b0;
  bit m_b = 1'b0;

  always #2.5 clk = ~clk;

  alu16 u0 (
    .clk(clk), .clk_en(clk_en), .rst(rst),
    .op_two(op_two), .op_one(op_one), .op_addi(op_addi), .op_subi(op_subi), .op_mem(op_mem),
    .func(func), .set_carry(set_carry), .set_borrow(set_borrow),
    .opa(opa), .opb(opb), .imm(imm), .result(result), .carry_out(carry_out)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference model, written in integer arithmetic.
  function automatic void model(input bit two, input bit one, input bit addi, input bit subi,
                                input bit mem, input int fn, input int a, input int b, input int im,
                                output int res, output bit do_c, output bit nc,
                                output bit do_b, output bit nb, output string tag);
    int t;
    do_c = 0; do_b = 0; nc = 0; nb = 0; res = 0; tag = "R9";
    if (two) begin
      tag = "R10/R3";
      case (fn)
        0, 1: begin t = a + b + ((fn == 1) ? int'(m_c) : 0); res = t % 65536; do_c = 1; nc = (t > 65535); end
        2, 3: begin t = a - b - ((fn == 3) ? int'(m_b) : 0); res = (t + 131072) % 65536; do_b = 1; nb = (t < 0); tag = "R4"; end
        4: begin res = a & b; tag = "R7"; end
        5: begin res = a | b; tag = "R7"; end
        6: begin res = a ^ b; tag = "R7"; end
        default: begin res = (~(a ^ b)) & 65535; tag = "R7"; end
      endcase
    end else if (one) begin
      tag = "R8";
      case (fn)
        0: res = 65535 - a;
        1: res = (a * 2) % 65536;
        2: res = a / 2;
        3: res = a;
        default: res = 0;
      endcase
    end else if (addi) begin
      t = a + im; res = t % 65536; do_c = 1; nc = (t > 65535); tag = "R3";
    end else if (subi) begin
      t = a - im; res = (t + 65536) % 65536; do_b = 1; nb = (t < 0); tag = "R4";
    end else if (mem) begin
      res = (a + im) % 65536; tag = "R5";
    end
  endfunction

  // Apply one cycle of stimulus, check the result, update the model, check carry.
  task automatic step(input bit two, input bit one, input bit addi, input bit subi, input bit mem,
                      input int fn, input int a, input int b, input int im,
                      input bit sc, input bit sb, input bit en, input string ovr);
    int res; bit do_c, nc, do_b, nb; string tag;
    @(negedge clk);
    op_two = two; op_one = one; op_addi = addi; op_subi = subi; op_mem = mem;
    func = 3'(fn); opa = 16'(a); opb = 16'(b); imm = 6'(im);
    set_carry = sc; set_borrow = sb; clk_en = en;
    model(two, one, addi, subi, mem, fn, a, b, im, res, do_c, nc, do_b, nb, tag);
    if (ovr != "") tag = ovr;
    #1;
    check({tag, " result"}, result, 16'(res));
    if (en) begin
      if (sc) m_c = 1; else if (do_c) m_c = nc;
      if (sb) m_b = 1; else if (do_b) m_b = nb;
    end
    @(posedge clk); #1;
    check({(en ? tag : "R2"), " carry"}, {15'd0, carry_out}, {15'd0, m_c});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; clk_en = 0; op_two = 0; op_one = 0; op_addi = 0; op_subi = 0; op_mem = 0;
    func = 0; set_carry = 0; set_borrow = 0; opa = 0; opb = 0; imm = 0;
    // Set both bits, then reset must clear them.
    @(negedge clk); rst = 0; clk_en = 1; set_carry = 1; set_borrow = 1;
    @(negedge clk); set_carry = 0; set_borrow = 0; rst = 1;
    @(negedge clk); rst = 0; m_c = 0; m_b = 0;
    #1 check("R1 carry after reset", {15'd0, carry_out}, 16'd0);
    step(1,0,0,0,0, 3, 16'h1234, 16'h1234, 0, 0,0,1, "R1");      // SUBB: no stale borrow
    // R3 32-bit chain: 0x0001_FFFF + 0x0000_0001
    step(1,0,0,0,0, 0, 16'hFFFF, 16'h0001, 0, 0,0,1, "R3");
    step(1,0,0,0,0, 1, 16'h0001, 16'h0000, 0, 0,0,1, "R3");
    // R2: overflow with enable low keeps carry at 0
    step(1,0,0,0,0, 0, 16'hFFFF, 16'hFFFF, 0, 0,0,0, "R2");
    step(1,0,0,0,0, 1, 16'h0000, 16'h0000, 0, 0,0,1, "R2");
    // R5: overflowing address generation leaves carry at 0
    step(0,0,0,0,1, 0, 16'hFFF0, 0, 63, 0,0,1, "R5");
    step(0,0,1,0,0, 0, 16'hFFFF, 0, 1, 0,0,1, "R3");              // carry now 1
    step(0,0,0,0,1, 0, 16'h0010, 0, 5, 0,0,1, "R5");              // carry stays 1
    // R4: borrow chain 0x0000_0000 - 0x0000_0001
    step(1,0,0,0,0, 2, 16'h0000, 16'h0001, 0, 0,0,1, "R4");
    step(1,0,0,0,0, 3, 16'h0000, 16'h0000, 0, 0,0,1, "R4");
    step(0,0,0,1,0, 0, 16'h0003, 0, 63, 0,0,1, "R4");
    step(1,0,0,0,0, 1, 16'h0005, 16'h0005, 0, 0,0,1, "R3");       // ADDC must not use borrow
    // R6: commands win over same-cycle updates
    step(1,0,0,0,0, 0, 16'h0001, 16'h0001, 0, 1,0,1, "R6");
    step(1,0,0,0,0, 2, 16'h0009, 16'h0001, 0, 0,1,1, "R6");
    step(1,0,0,0,0, 3, 16'h0009, 16'h0001, 0, 0,0,1, "R6");
    // R8 corners and R10 priority
    step(0,1,0,0,0, 1, 16'h8001, 0, 0, 0,0,1, "R8");
    step(0,1,0,0,0, 2, 16'h8001, 0, 0, 0,0,1, "R8");
    step(0,1,0,0,0, 6, 16'hABCD, 0, 0, 0,0,1, "R8");
    step(0,0,0,0,0, 0, 16'hABCD, 16'h1111, 9, 0,0,1, "R9");
    step(0,1,1,1,1, 3, 16'h4321, 0, 7, 0,0,1, "R10");
    step(0,0,1,1,1, 0, 16'hFFFF, 0, 2, 0,0,1, "R10");
    step(1,1,0,0,1, 7, 16'h00FF, 16'h0F0F, 1, 0,0,1, "R10");
    // Random mix, fixed seed.
    void'($urandom(32'd1234));
    for (int i = 0; i < 1500; i++) begin
      int sel = $urandom_range(0, 9);
      bit two = (sel < 4), one = (sel == 4 || sel == 5), ad = (sel == 6), sb = (sel == 7), mm = (sel == 8);
      if ($urandom_range(0, 9) == 0) begin one = 1; mm = 1; end
      step(two, one, ad, sb, mm, $urandom_range(0, 7),
           ($urandom_range(0, 3) == 0) ? 16'hFFFF : $urandom_range(0, 65535),
           $urandom_range(0, 65535), $urandom_range(0, 63),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 4) != 0), "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule